// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo stream in on three wires: a bit clock, a channel-select line and a data line. The far end drives all three, so the block is a slave and only listens. It over-samples the three lines with the system clock and rebuilds each channel slot in a shift register. When both words of a stereo frame are complete, it presents them on two parallel 20-bit outputs with a one-cycle strobe. The system clock must run at least 256 times the sample rate. Each bit-clock half period must cover at least two system clock cycles.

One receiver handles three framings. In I2S framing the data lags channel select by one bit. In MSB-justified framing the first bit of a slot is the most significant one. In LSB-justified framing the word sits at the end of the slot, so its start depends on the selected word length. A 2-bit code picks I2S or LSB-justified with 16, 18 or 20 bits. A separate mode input selects MSB-justified framing.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is low, and on the first cycle after it, `left_o` and `right_o` read zero and `pair_valid_o` is low.
- R2: When `msb_mode_i` is low, `fmt_code_i` selects the framing: 00 = I2S, 01 = LSB-justified 16-bit, 10 = LSB-justified 18-bit, 11 = LSB-justified 20-bit. When `msb_mode_i` is high, the framing is MSB-justified whatever the code is.
- R3: Channel select low marks the left slot and high marks the right slot. A pair is presented once its right slot has ended. That happens at the first sampled bit-clock rise of the next left slot, and `pair_valid_o` rises within four system cycles of that rise.
- R4: In I2S framing, the most significant bit is the data sampled on the second bit-clock rise after channel select changes. The slot ends with the bit sampled on the first rise after the next change.
- R5: In MSB-justified framing, the most significant bit is the data sampled on the first bit-clock rise after channel select changes.
- R6: In an LSB-justified framing of N bits, the word is the last N bits sampled before channel select toggles, with its last bit as the LSB. The word is placed in bits 19 down to 20-N, and the lower 20-N output bits are zero.
- R7: In the MSB-first framings, a slot shorter than 20 bits gives its bits left-aligned with zeros below them. A slot longer than 20 bits gives only its first 20 bits, and the later bits are ignored.
- R8: `pair_valid_o` is high for exactly one system cycle per pair. `left_o` and `right_o` change only in the cycle in which `pair_valid_o` is high.
- R9: The partial slot in progress when reset is released is discarded. No pair is presented until a complete left slot and then a complete right slot have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 256 times the sample rate |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock from the far end (asynchronous) |
| lrclk_i | input | 1 | Channel select, low = left (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first (asynchronous) |
| fmt_code_i | input | 2 | Framing code, see R2 |
| msb_mode_i | input | 1 | High selects MSB-justified framing |
| left_o | output | 20 | Left sample, left-aligned two's complement |
| right_o | output | 20 | Right sample, left-aligned two's complement |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The checker watches these properties on every cycle:
- the strobe is one cycle wide;
- the outputs hold steady between strobes;
- a strobe only follows a sampled bit-clock rise;
- in the 16- and 18-bit LSB-justified framings, the unused low bits are zero.

Only the bench scenarios can show the rest. They cover where the word sits within a slot in each framing: the one-bit I2S lag, the end alignment of LSB-justified words, zero fill for short slots and dropped bits for long ones. They also cover discarding the partial slot after reset. The bench sweeps every framing across slot lengths of 16, 20, 24 and 32 bits.

// File: rtl/sarx_pkg.sv
// Shared definitions for the serial audio receiver.
// Assumes: LSB-justified word lengths never exceed the output sample width.
package sarx_pkg;

    // Framing decoded from the static select code and the mode input
    typedef enum logic [2:0] {
        FMT_I2S,
        FMT_MSBJ,
        FMT_LSB_SHORT,
        FMT_LSB_MID,
        FMT_LSB_LONG
    } fmt_e;

    localparam int LSB_SHORT_W = 16;
    localparam int LSB_MID_W   = 18;
    localparam int LSB_LONG_W  = 20;

    // Map the select code and mode input onto a framing
    function automatic fmt_e decode_fmt(input logic [1:0] code, input logic msb_mode);
        fmt_e f;
        if (msb_mode) begin
            f = FMT_MSBJ;
        end else begin
            case (code)
                2'b01:   f = FMT_LSB_SHORT;
                2'b10:   f = FMT_LSB_MID;
                2'b11:   f = FMT_LSB_LONG;
                default: f = FMT_I2S;
            endcase
        end
        return f;
    endfunction

endpackage

// File: rtl/sarx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit lines.
// Assumes: all bits change far apart relative to the system clock, so one
// common delay keeps them mutually aligned.
module sarx_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_i;
                end
            end else begin : g_next
                // Later stages: pass the previous stage along
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/sarx_slot.sv
// Slot tracker: finds bit-clock rises, shifts in data and reports each
// completed channel slot (raw bits, length and channel).
// Assumes: at most SLOT_W bits per slot. With delay_tag set (I2S), slots are
// tagged by the channel select seen one bit earlier.
module sarx_slot #(
    parameter int SLOT_W = 32,
    localparam int CNT_W = $clog2(SLOT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_s,
    input  logic              lrclk_s,
    input  logic              sdata_s,
    input  logic              delay_tag,
    output logic              bit_rise,
    output logic              done,
    output logic              done_chan,
    output logic [SLOT_W-1:0] done_bits,
    output logic [CNT_W-1:0]  done_len
);
    logic              bclk_d;
    logic              lr_prev;
    logic              tag_q;
    logic              started;
    logic [SLOT_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              tag_now;
    logic              boundary;

    // Rise of the synchronized bit clock and the slot tag for this bit
    assign bit_rise = bclk_s & ~bclk_d;
    assign tag_now  = delay_tag ? lr_prev : lrclk_s;
    assign boundary = bit_rise && (tag_now != tag_q);

    // Completed-slot report, valid only for slots that began at a boundary
    assign done      = boundary && started;
    assign done_chan = tag_q;
    assign done_bits = shreg;
    assign done_len  = cnt;

    // Delay register for bit-clock edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_s;
    end

    // Per-bit state: tags, shift register and saturating bit count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_prev <= 1'b0;
            tag_q   <= 1'b0;
            started <= 1'b0;
            shreg   <= '0;
            cnt     <= '0;
        end else if (bit_rise) begin
            lr_prev <= lrclk_s;
            tag_q   <= tag_now;
            if (boundary) begin
                started <= 1'b1;
                shreg   <= {{(SLOT_W-1){1'b0}}, sdata_s};
                cnt     <= CNT_W'(1);
            end else begin
                shreg   <= {shreg[SLOT_W-2:0], sdata_s};
                if (cnt != CNT_W'(SLOT_W)) cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sarx_align.sv
// Word aligner: turns the raw bits of a slot into a left-aligned sample
// according to the framing.
// Assumes: len >= 1, and for LSB-justified framings, len >= the word length.
module sarx_align
    import sarx_pkg::*;
#(
    parameter int SLOT_W   = 32,
    parameter int SAMPLE_W = 20,
    localparam int CNT_W   = $clog2(SLOT_W + 1)
) (
    input  fmt_e                fmt,
    input  logic [SLOT_W-1:0]   bits,
    input  logic [CNT_W-1:0]    len,
    output logic [SAMPLE_W-1:0] sample
);
    logic [SLOT_W-1:0]   msb_first;
    logic [SAMPLE_W-1:0] tail;

    // Take the last n bits and move them to the top of the sample
    function automatic logic [SAMPLE_W-1:0] pick_tail(input logic [SAMPLE_W-1:0] t, input int n);
        logic [SAMPLE_W-1:0] mask;
        mask = {SAMPLE_W{1'b1}} >> (SAMPLE_W - n);
        return (t & mask) << (SAMPLE_W - n);
    endfunction

    assign msb_first = bits << (CNT_W'(SLOT_W) - len);
    assign tail      = bits[SAMPLE_W-1:0];

    // Select the alignment rule of the current framing
    always_comb begin
        case (fmt)
            FMT_LSB_SHORT: sample = pick_tail(tail, LSB_SHORT_W);
            FMT_LSB_MID:   sample = pick_tail(tail, LSB_MID_W);
            FMT_LSB_LONG:  sample = pick_tail(tail, LSB_LONG_W);
            default:       sample = msb_first[SLOT_W-1 -: SAMPLE_W];
        endcase
    end
endmodule

// File: rtl/serial_audio_rx.sv
// Serial audio receiver (slave): synchronizes the three serial lines, tracks
// channel slots, aligns each word and presents stereo pairs with a strobe.
// Assumes: the system clock is at least 256x the sample rate, and each bit-clock
// half period spans two or more system cycles.
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SAMPLE_W    = 20,
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(SLOT_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                lrclk_i,
    input  logic                sdata_i,
    input  logic [1:0]          fmt_code_i,
    input  logic                msb_mode_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                pair_valid_o
);
    fmt_e                fmt;
    logic [2:0]          line_s;
    logic                bit_rise;
    logic                done;
    logic                done_chan;
    logic [SLOT_W-1:0]   done_bits;
    logic [CNT_W-1:0]    done_len;
    logic [SAMPLE_W-1:0] sample;
    logic [SAMPLE_W-1:0] left_hold;
    logic                have_left;

    assign fmt = decode_fmt(fmt_code_i, msb_mode_i);

    sarx_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bclk_i, lrclk_i, sdata_i}),
        .sync_o  (line_s)
    );

    sarx_slot #(.SLOT_W(SLOT_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_s    (line_s[2]),
        .lrclk_s   (line_s[1]),
        .sdata_s   (line_s[0]),
        .delay_tag (fmt == FMT_I2S),
        .bit_rise  (bit_rise),
        .done      (done),
        .done_chan (done_chan),
        .done_bits (done_bits),
        .done_len  (done_len)
    );

    sarx_align #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) u_align (
        .fmt    (fmt),
        .bits   (done_bits),
        .len    (done_len),
        .sample (sample)
    );

    // Pair assembly: hold the left word, present both words when the right one completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold    <= '0;
            have_left    <= 1'b0;
            left_o       <= '0;
            right_o      <= '0;
            pair_valid_o <= 1'b0;
        end else begin
            pair_valid_o <= 1'b0;
            if (done) begin
                if (!done_chan) begin
                    left_hold <= sample;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_o       <= left_hold;
                    right_o      <= sample;
                    pair_valid_o <= 1'b1;
                    have_left    <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sarx_checker.sv
// Cycle-level properties of the receiver outputs; attached to the top by bind.
module sarx_checker #(
    parameter int SAMPLE_W = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          fmt_code_i,
    input logic                msb_mode_i,
    input logic                bit_rise,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                pair_valid_o
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |=> !pair_valid_o);

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid_o |-> ($stable(left_o) && $stable(right_o)));

    a_r3_after_bit_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |-> $past(bit_rise));

    a_r6_short_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && !msb_mode_i && fmt_code_i == 2'b01)
        |-> (left_o[SAMPLE_W-17:0] == '0 && right_o[SAMPLE_W-17:0] == '0));

    a_r6_mid_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && !msb_mode_i && fmt_code_i == 2'b10)
        |-> (left_o[SAMPLE_W-19:0] == '0 && right_o[SAMPLE_W-19:0] == '0));
endmodule

bind serial_audio_rx sarx_checker #(.SAMPLE_W(SAMPLE_W)) u_sarx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_code_i   (fmt_code_i),
    .msb_mode_i   (msb_mode_i),
    .bit_rise     (bit_rise),
    .left_o       (left_o),
    .right_o      (right_o),
    .pair_valid_o (pair_valid_o)
);

// File: tb/serial_audio_rx_bench.sv
// Sweep of all framings over several slot lengths, expected words computed arithmetically.
module serial_audio_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt_code = 2'b00;
    logic        msb_mode = 1'b0;
    logic [19:0] left_o;
    logic [19:0] right_o;
    logic        pair_valid_o;

    int checks = 0;
    int fails  = 0;
    int got    = 0;
    int mode   = 0;
    logic [19:0] exp_l [0:4];
    logic [19:0] exp_r [0:4];
    logic [31:0] words [0:4][0:1];
    logic        pending = 1'b0;
    logic        done_all = 1'b0;

    always #5 clk = ~clk;

    serial_audio_rx u_serial_audio_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_i       (bclk),
        .lrclk_i      (lrclk),
        .sdata_i      (sdata),
        .fmt_code_i   (fmt_code),
        .msb_mode_i   (msb_mode),
        .left_o       (left_o),
        .right_o      (right_o),
        .pair_valid_o (pair_valid_o)
    );

    function automatic string req_of(input int m, input int slot);
        if (m == 0) return (slot == 20) ? "R4" : "R4/R7";
        if (m == 1) return (slot == 20) ? "R5" : "R5/R7";
        return "R6";
    endfunction

    function automatic logic [19:0] expect_word(input int m, input int slot, input logic [31:0] d);
        logic [31:0] t;
        int n;
        if (m <= 1) begin
            t = d & (32'hFFFF_FFFF << (32 - slot));
            return t[31:12];
        end
        n = (m == 2) ? 16 : (m == 3) ? 18 : 20;
        t = (d & ((32'h1 << n) - 32'h1)) << (20 - n);
        return t[19:0];
    endfunction

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bit period: data and select change while the bit clock is low
    task automatic send_bit(input logic w, input logic b);
        @(negedge clk);
        bclk  = 1'b0;
        lrclk = w;
        if (mode == 0) begin
            sdata   = pending;
            pending = b;
        end else begin
            sdata = b;
        end
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Pair monitor, sampled on the falling system clock edge
    always @(negedge clk) begin
        if (rst_n && pair_valid_o) begin
            if (got < 3) begin
                check({req_of(mode, 0), " R2/R3 left"},  left_o,  exp_l[got + 1]);
                check({req_of(mode, 0), " R2/R3 right"}, right_o, exp_r[got + 1]);
            end
            got++;
        end
    end

    task automatic run_config(input int m, input int slot);
        logic [31:0] seed;
        mode = m;
        msb_mode = (m == 1);
        fmt_code = (m == 0) ? 2'b00 : (m == 1) ? 2'b10 : 2'(m - 1);
        rst_n = 1'b0;
        bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0; pending = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 left reset", left_o, 20'h0);
        check("R1 valid reset", {19'h0, pair_valid_o}, 20'h0);
        seed = 32'h1234_5678 + 32'(m * 97 + slot);
        for (int f = 0; f < 5; f++) begin
            for (int c = 0; c < 2; c++) begin
                seed = seed * 32'h0019_660D + 32'h3C6E_F35F;
                words[f][c] = (f == 1 && c == 0) ? 32'h8000_0001 :
                              (f == 2 && c == 1) ? 32'hFFFF_FFFF : seed;
            end
            exp_l[f] = expect_word(m, slot, words[f][0]);
            exp_r[f] = expect_word(m, slot, words[f][1]);
        end
        got = 0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 right after reset", right_o, 20'h0);
        for (int f = 0; f < 5; f++) begin
            for (int c = 0; c < 2; c++) begin
                for (int i = 0; i < slot; i++) begin
                    send_bit(c[0], (m <= 1) ? words[f][c][31 - i] : words[f][c][slot - 1 - i]);
                end
            end
        end
        repeat (10) @(negedge clk);
        check("R9 pair count", 20'(got), 20'd3);
    endtask

    initial begin
        int slots [4] = '{16, 20, 24, 32};
        for (int m = 0; m < 5; m++) begin
            for (int s = 0; s < 4; s++) begin
                if (m >= 3 && slots[s] < ((m == 3) ? 18 : 20)) continue;
                run_config(m, slots[s]);
            end
        end
        done_all = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_all) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule